// File: doc/BRIEF.md
# Tagged Receive Byte Queue with Overflow Lockout

This block sits behind a serial frame receiver and holds the bytes it recovers until software takes them. Every byte is pushed together with a 2-bit tag saying where in a packet it falls. The oldest entry, with its data, its tag and a valid bit, is shown at the outputs before it is popped. Software can therefore learn whether a byte ends a packet, and whether that packet was good, before it consumes the byte.

Two sticky interrupt bits report packet ends. One is raised when a byte ending a packet is written. The other is raised when such a byte reaches the head of the queue. A single clear strobe clears both.

When the queue is full, an incoming byte is discarded and the queue stops accepting bytes. It starts accepting again only at the next opening flag, and only if space has been freed by then. Stored entries are never overwritten. Because the tail of the damaged packet never reaches the queue, the next packet's first-byte tag follows the earlier first-byte tag with no last-byte tag in between, and that pattern marks the overflow. A separate sticky flag also records every discarded byte.

Top module: `tagged_pkt_fifo`

## Requirements
- R1: Entries leave the queue in the order they were accepted. The head outputs show the data and tag of the oldest entry before it is popped, and they stay unchanged while no pop occurs.
- R2: When the queue is empty, `head_valid` is 0, and `level` gives the number of stored entries.
- R3: Tags are encoded as follows: 2'b00 is a middle byte, 2'b01 is the first byte of a packet, 2'b10 is the last byte of a good packet, and 2'b11 is the last byte of a bad packet. Bit 1 set means last byte.
- R4: `irq_eop_wr` becomes 1 on the edge that accepts a byte whose tag has bit 1 set. It stays 1 until an `irq_clear` strobe. If a new set and a clear occur in the same cycle, the set wins.
- R5: `irq_eop_head` becomes 1 on the edge where an entry whose tag has bit 1 set becomes the head. This happens either through a pop, or through a write into an empty queue (or into a queue holding one entry that is popped in the same cycle). It is sticky, cleared by `irq_clear`, and the set wins over a clear in the same cycle.
- R6: A write offered while the queue is full is discarded. The stored entries and `level` are unchanged, and `ovf_flag` becomes 1.
- R7: After a discard, every later write is discarded until a `frame_start` arrives while the queue is not full. A `frame_start` that arrives while the queue is still full leaves the lockout in place.
- R8: A write offered in the same cycle as a `frame_start` that ends the lockout is accepted.
- R9: `ovf_flag` stays 1 until an `ovf_clear` strobe. A discard in the same cycle as the clear keeps it at 1.
- R10: While `rx_en` is 0, writes and `frame_start` are ignored and set no flags. Pops, the head outputs and the flags keep working.
- R11: A pop offered while the queue is empty has no effect. A push and a pop in the same cycle leave `level` unchanged.
- R12: After reset, the queue is empty, `level` is 0, all flags are 0 and no lockout is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive side enable; gates writes and frame_start |
| frame_start | input | 1 | Pulse marking an opening flag |
| wr_valid | input | 1 | Byte offered for writing |
| wr_data | input | DATA_W | Byte to store |
| wr_tag | input | 2 | Packet position tag of the byte |
| rd_pop | input | 1 | Remove the head entry |
| irq_clear | input | 1 | Clear both end-of-packet interrupt bits |
| ovf_clear | input | 1 | Clear the overflow flag |
| head_valid | output | 1 | Head entry present |
| head_data | output | DATA_W | Data of the head entry |
| head_tag | output | 2 | Tag of the head entry |
| level | output | $clog2(DEPTH+1) | Number of stored entries |
| full | output | 1 | Queue holds DEPTH entries |
| irq_eop_wr | output | 1 | Sticky: a last byte was written |
| irq_eop_head | output | 1 | Sticky: a last byte reached the head |
| ovf_flag | output | 1 | Sticky: a byte was discarded |

## Verification
All results appear one clock edge after the stimulus. The outputs `level`, `full`, the lockout state and the three sticky bits are registers. The head outputs are read from storage through registered pointers, so a pop or a write into an empty queue shows up at the head right after the edge that performs it. The bench applies each stimulus for exactly one edge and samples 1 ns after that edge, before the next stimulus is driven. That makes every expected value a function of the single preceding cycle. The sweeps run several fill-and-drain rounds of different lengths so that the pointers wrap, and the expected bytes and tags are computed from the round and index numbers.

// File: rtl/tpf_pkg.sv
package tpf_pkg;
   typedef enum logic [1:0] {
      TAG_MID      = 2'b00,
      TAG_FIRST    = 2'b01,
      TAG_LAST_OK  = 2'b10,
      TAG_LAST_BAD = 2'b11
   } pkt_tag_e;

   localparam int TAG_W = 2;

   function automatic logic tag_is_last(input logic [TAG_W-1:0] t);
      return t[1];
   endfunction
endpackage

// File: rtl/tpf_store.sv
module tpf_store #(
   parameter int DEPTH = 8,
   parameter int W     = 10,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic [W-1:0]  din,
   output logic [W-1:0]  head,
   output logic [W-1:0]  next_head,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);
   localparam bit POW2 = (DEPTH & (DEPTH - 1)) == 0;

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;

   generate
      if (DEPTH < 2) begin : g_depth_bad
         $error("tpf_store: DEPTH must be at least 2");
      end
      if (POW2) begin : g_wrap_nat
         assign wr_nxt = wr_ptr + AW'(1);
         assign rd_nxt = rd_ptr + AW'(1);
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   assign head      = mem[rd_ptr];
   assign next_head = mem[rd_nxt];
   assign full      = (count == CW'(DEPTH));
   assign empty     = (count == '0);

   // R6
   push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   // R11
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   // R1
   head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pop && !empty) |=> $stable(head));
endmodule

// File: rtl/tpf_admit.sv
module tpf_admit (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_en,
   input  logic wr_valid,
   input  logic frame_start,
   input  logic full,
   input  logic ovf_clear,
   output logic push,
   output logic drop,
   output logic ovf_flag
);
   logic locked, start_ok, lock_eff, offer;

   assign start_ok = rx_en && frame_start && !full;
   assign lock_eff = locked && !start_ok;
   assign offer    = rx_en && wr_valid;
   assign push     = offer && !lock_eff && !full;
   assign drop     = offer && !push;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         locked   <= 1'b0;
         ovf_flag <= 1'b0;
      end else begin
         if (drop)          locked <= 1'b1;
         else if (start_ok) locked <= 1'b0;
         if (drop)           ovf_flag <= 1'b1;
         else if (ovf_clear) ovf_flag <= 1'b0;
      end
   end

   // R7
   lockout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> (!push || frame_start));
   // R6
   drop_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> ovf_flag);
   // R9
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !ovf_clear) |=> ovf_flag);
endmodule

// File: rtl/tpf_irq.sv
module tpf_irq #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          push_last,
   input  logic          pop,
   input  logic [CW-1:0] count,
   input  logic          next_last,
   input  logic          irq_clear,
   output logic          irq_wr,
   output logic          irq_head
);
   logic set_wr, set_head, via_pop, via_push;

   assign via_pop  = pop && (count > CW'(1)) && next_last;
   assign via_push = push && push_last &&
                     ((count == '0) || ((count == CW'(1)) && pop));
   assign set_head = via_pop || via_push;
   assign set_wr   = push && push_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_wr   <= 1'b0;
         irq_head <= 1'b0;
      end else begin
         if (set_wr)         irq_wr <= 1'b1;
         else if (irq_clear) irq_wr <= 1'b0;
         if (set_head)       irq_head <= 1'b1;
         else if (irq_clear) irq_head <= 1'b0;
      end
   end

   // R4
   eop_wr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_wr && !irq_clear) |=> irq_wr);
   // R5
   eop_head_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_head && !irq_clear) |=> irq_head);
endmodule

// File: rtl/tagged_pkt_fifo.sv
module tagged_pkt_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8,
   localparam int CW    = $clog2(DEPTH + 1),
   localparam int EW    = DATA_W + tpf_pkg::TAG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              frame_start,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        wr_tag,
   input  logic              rd_pop,
   input  logic              irq_clear,
   input  logic              ovf_clear,
   output logic              head_valid,
   output logic [DATA_W-1:0] head_data,
   output logic [1:0]        head_tag,
   output logic [CW-1:0]     level,
   output logic              full,
   output logic              irq_eop_wr,
   output logic              irq_eop_head,
   output logic              ovf_flag
);
   logic          push, drop, pop, empty;
   logic [EW-1:0] head_e, next_e;

   generate
      if (DATA_W < 1) begin : g_width_bad
         $error("tagged_pkt_fifo: DATA_W must be at least 1");
      end
   endgenerate

   assign pop = rd_pop && !empty;

   tpf_admit u_admit (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_en      (rx_en),
      .wr_valid   (wr_valid),
      .frame_start(frame_start),
      .full       (full),
      .ovf_clear  (ovf_clear),
      .push       (push),
      .drop       (drop),
      .ovf_flag   (ovf_flag)
   );

   tpf_store #(.DEPTH(DEPTH), .W(EW)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push),
      .pop      (pop),
      .din      ({wr_tag, wr_data}),
      .head     (head_e),
      .next_head(next_e),
      .count    (level),
      .full     (full),
      .empty    (empty)
   );

   tpf_irq #(.CW(CW)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push),
      .push_last(tpf_pkg::tag_is_last(wr_tag)),
      .pop      (pop),
      .count    (level),
      .next_last(tpf_pkg::tag_is_last(next_e[EW-1 -: 2])),
      .irq_clear(irq_clear),
      .irq_wr   (irq_eop_wr),
      .irq_head (irq_eop_head)
   );

   assign head_valid = !empty;
   assign head_data  = head_e[DATA_W-1:0];
   assign head_tag   = head_e[EW-1 -: 2];

   // R2
   empty_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !head_valid |-> (level == '0));
   // R10
   disabled_no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |-> (!push && !drop));
endmodule

// File: tb/tb_tagged_pkt_fifo.sv
`timescale 1ns/1ps
module tb_tagged_pkt_fifo;
   localparam int DW = 8;
   localparam int DP = 4;
   localparam int CW = $clog2(DP + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_en = 1'b1, frame_start = 1'b0, wr_valid = 1'b0, rd_pop = 1'b0;
   logic irq_clear = 1'b0, ovf_clear = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [1:0] wr_tag = '0;
   logic head_valid, full, irq_eop_wr, irq_eop_head, ovf_flag;
   logic [DW-1:0] head_data;
   logic [1:0] head_tag;
   logic [CW-1:0] level;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   tagged_pkt_fifo #(.DATA_W(DW), .DEPTH(DP)) dut (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .frame_start(frame_start),
      .wr_valid(wr_valid), .wr_data(wr_data), .wr_tag(wr_tag), .rd_pop(rd_pop),
      .irq_clear(irq_clear), .ovf_clear(ovf_clear), .head_valid(head_valid),
      .head_data(head_data), .head_tag(head_tag), .level(level), .full(full),
      .irq_eop_wr(irq_eop_wr), .irq_eop_head(irq_eop_head), .ovf_flag(ovf_flag)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input logic wv, input logic [7:0] d, input logic [1:0] t,
                      input logic fs, input logic pp, input logic ic, input logic oc);
      wr_valid = wv; wr_data = d; wr_tag = t; frame_start = fs;
      rd_pop = pp; irq_clear = ic; ovf_clear = oc;
      @(posedge clk); #1;
      wr_valid = 0; frame_start = 0; rd_pop = 0; irq_clear = 0; ovf_clear = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk); #1;
      rst_n = 1'b1;
      // R12 / R2 reset state
      chk("R12 level", level, 0);
      chk("R2 head_valid empty", head_valid, 0);
      chk("R12 flags", {irq_eop_wr, irq_eop_head, ovf_flag, full}, 0);

      // R1 R3 first byte into empty queue
      cyc(1, 8'hA0, 2'b01, 1, 0, 0, 0);
      chk("R1 head_data", head_data, 8'hA0);
      chk("R3 head_tag first", head_tag, 2'b01);
      chk("R2 level one", level, 1);
      cyc(1, 8'hA1, 2'b00, 0, 0, 0, 0);
      cyc(1, 8'hA2, 2'b00, 0, 0, 0, 0);
      chk("R4 no irq for middle", irq_eop_wr, 0);
      cyc(1, 8'hA3, 2'b10, 0, 0, 0, 0);
      chk("R4 irq_eop_wr set", irq_eop_wr, 1);
      chk("R2 full at depth", {full, level}, {1'b1, CW'(DP)});
      chk("R1 head held", head_data, 8'hA0);

      // R6 write while full
      cyc(1, 8'hB0, 2'b01, 0, 0, 0, 0);
      chk("R6 ovf_flag", ovf_flag, 1);
      chk("R6 level unchanged", level, DP);
      chk("R6 head unchanged", head_data, 8'hA0);
      // R7 frame_start while still full keeps lockout
      cyc(0, 8'h00, 2'b00, 1, 0, 0, 0);
      cyc(0, 8'h00, 2'b00, 0, 1, 0, 0);
      chk("R1 pop advances head", head_data, 8'hA1);
      chk("R11 level after pop", level, 3);
      cyc(1, 8'hB1, 2'b00, 0, 0, 0, 0);
      chk("R7 locked write dropped", level, 3);
      // R8 frame_start with write ends lockout
      cyc(1, 8'hC0, 2'b01, 1, 0, 0, 0);
      chk("R8 write accepted with frame_start", level, 4);
      // R9 set wins over clear, then clear
      cyc(1, 8'hC1, 2'b00, 0, 0, 0, 1);
      chk("R9 set wins over clear", ovf_flag, 1);
      cyc(0, 8'h00, 2'b00, 0, 0, 0, 1);
      chk("R9 ovf cleared", ovf_flag, 0);
      cyc(0, 8'h00, 2'b00, 0, 0, 1, 0);
      chk("R4 irq_eop_wr cleared", irq_eop_wr, 0);
      chk("R5 irq_eop_head idle", irq_eop_head, 0);

      // R5 last byte reaches head by pop
      cyc(0, 8'h00, 2'b00, 0, 1, 0, 0);
      chk("R1 head A2", head_data, 8'hA2);
      chk("R5 no irq on middle head", irq_eop_head, 0);
      cyc(0, 8'h00, 2'b00, 0, 1, 0, 0);
      chk("R3 head_tag last good", head_tag, 2'b10);
      chk("R5 irq_eop_head by pop", irq_eop_head, 1);
      cyc(0, 8'h00, 2'b00, 0, 0, 1, 0);
      chk("R5 irq_eop_head cleared", irq_eop_head, 0);
      cyc(0, 8'h00, 2'b00, 0, 1, 0, 0);
      chk("R1 head C0", {head_tag, head_data}, {2'b01, 8'hC0});
      cyc(0, 8'h00, 2'b00, 0, 1, 0, 0);
      chk("R2 empty after drain", {head_valid, level}, 0);
      cyc(0, 8'h00, 2'b00, 0, 1, 0, 0);
      chk("R11 pop on empty ignored", {head_valid, level}, 0);

      // R5 write of last byte into empty queue (still locked from C1 drop)
      cyc(1, 8'hD0, 2'b11, 1, 0, 0, 0);
      chk("R3 head_tag last bad", {head_tag, head_data}, {2'b11, 8'hD0});
      chk("R5 irq_eop_head by write", irq_eop_head, 1);
      chk("R4 irq_eop_wr by bad last", irq_eop_wr, 1);
      cyc(0, 8'h00, 2'b00, 0, 0, 1, 0);
      chk("R4 R5 both cleared", {irq_eop_wr, irq_eop_head}, 0);
      // R11 push and pop together, R4 R5 set wins over clear
      cyc(1, 8'hE1, 2'b10, 0, 1, 1, 0);
      chk("R11 level with push+pop", level, 1);
      chk("R1 head after push+pop", head_data, 8'hE1);
      chk("R4 set wins", irq_eop_wr, 1);
      chk("R5 set wins", irq_eop_head, 1);

      // R10 disabled receive side
      rx_en = 1'b0;
      cyc(1, 8'hF0, 2'b00, 1, 0, 0, 0);
      chk("R10 write ignored", level, 1);
      chk("R10 no ovf", ovf_flag, 0);
      cyc(0, 8'h00, 2'b00, 0, 1, 0, 0);
      chk("R10 pop works disabled", level, 0);
      rx_en = 1'b1;
      cyc(0, 8'h00, 2'b00, 0, 0, 1, 0);

      // R1 R3 sweep with pointer wrap
      for (int r = 0; r < 8; r++) begin
         int n;
         n = (r % DP) + 1;
         for (int i = 0; i < n; i++)
            cyc(1, 8'((r * 37 + i * 11) & 8'hFF),
                (i == n - 1) ? 2'b10 : ((i == 0) ? 2'b01 : 2'b00),
                (i == 0), 0, 0, 0);
         chk("R2 sweep level", level, n);
         for (int i = 0; i < n; i++) begin
            chk("R1 sweep data", head_data, (r * 37 + i * 11) & 8'hFF);
            chk("R3 sweep tag", head_tag,
                (i == n - 1) ? 2'b10 : ((i == 0) ? 2'b01 : 2'b00));
            cyc(0, 8'h00, 2'b00, 0, 1, 0, 0);
         end
         chk("R2 sweep drained", head_valid, 0);
      end
      chk("R6 no ovf during sweep", ovf_flag, 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule